// File: doc/BRIEF.md
# USB Host Port Suspend and Resume Clock-Gating Controller

This block sequences a USB host port through suspend, clock gating and resume. A suspend request from software makes the port drive a bus suspend. One cycle later the controller stops the PHY clock and gates the internal bus clock. The port then stays parked in that low-power state. A software resume request, or a remote wakeup detected from the downstream device, opens the path back out. The clock gate and the PHY stop are released first. The controller then waits a fixed settle window in core cycles. Only after that does it drive resume signalling on the bus.

Resume signalling is timed against a millisecond tick input, and it has a hard minimum length. A software resume ends only when software asks for it to be cleared and the minimum tick count has passed. A clear that arrives too early is remembered and takes effect at the minimum. A remote wakeup first waits a programmable window of 1 to 15 ms. It then drives resume for the minimum length and ends without software help. When resume signalling ends, the port reports normal operation again.

Top module: `usb_host_susp_ctrl`

## Requirements
- R1: While reset is asserted and right after it is released, normal_op_o is 1 and port_susp_o, stop_phy_clk_o, bus_clk_gate_o and resume_drv_o are all 0.
- R2: A suspend_req_i seen in normal operation sets port_susp_o on the next cycle with both clock controls still 0. One cycle later stop_phy_clk_o and bus_clk_gate_o both go to 1, and they stay at 1 until a resume or wakeup arrives.
- R3: A resume_req_i while gated clears stop_phy_clk_o and bus_clk_gate_o on the next cycle while port_susp_o stays 1. resume_drv_o stays 0 for exactly SETTLE_CYC cycles (default 4) before it rises, and port_susp_o falls when resume_drv_o rises.
- R4: resume_drv_o is never 1 while stop_phy_clk_o or bus_clk_gate_o is 1, and it only rises after a cycle with both clock controls at 0.
- R5: Software-started resume signalling lasts at least MIN_RESUME_MS ms ticks (default 20). A resume_clr_i given before that point is held pending, and resume_drv_o falls on the cycle after the MIN_RESUME_MS-th tick has been counted.
- R6: Without resume_clr_i, software-started resume signalling continues past the minimum. It falls within three cycles of a resume_clr_i given after the minimum.
- R7: When resume signalling ends, normal_op_o returns to 1 and all other outputs are 0.
- R8: A rwake_det_i while gated runs the same clock-restore window. It then waits wake_ms_i ms ticks with the clocks running and resume_drv_o at 0; a wake_ms_i value of 0 counts as 1. After that it drives resume for exactly MIN_RESUME_MS ticks and ends without any resume_clr_i.
- R9: A suspend_req_i given during clock restore, wakeup wait or resume signalling is ignored and not remembered, so the port stays out of suspend after normal operation returns.
- R10: resume_req_i, resume_clr_i and rwake_det_i given in normal operation have no effect on any output.
- R11: When resume_req_i and rwake_det_i arrive in the same cycle while gated, the software path wins: there is no wakeup wait, and resume signalling needs resume_clr_i to end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| suspend_req_i | input | 1 | Software request to suspend the port |
| resume_req_i | input | 1 | Software request to resume a suspended port |
| resume_clr_i | input | 1 | Software request to end resume signalling |
| rwake_det_i | input | 1 | Remote wakeup detected from the downstream device |
| wake_ms_i | input | WAKE_W | Remote wakeup wait in ms ticks (0 treated as 1) |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| port_susp_o | output | 1 | Port is driving or holding bus suspend |
| stop_phy_clk_o | output | 1 | Stop the PHY clock |
| bus_clk_gate_o | output | 1 | Gate the internal bus clock |
| resume_drv_o | output | 1 | Drive resume signalling on the bus |
| normal_op_o | output | 1 | Port is in normal operation |

## Verification
Suspend-then-resume is exercised four ways. The first is a software resume with a clear given right after signalling starts, which shows whether the minimum is enforced and the early clear is remembered. The second is a software resume with no clear, which shows whether signalling persists until software ends it. The third is a remote wakeup with wait values 5, 0 and 15, which shows the wait window, the zero-to-one rule and the self-ending resume. The fourth is a simultaneous software and remote request, which shows which path takes priority. Stray requests in normal operation, and suspend requests given during restore and resume, show that requests outside their valid phase leave no trace.

// File: rtl/usb_susp_pkg.sv
package usb_susp_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL     = 3'd0,
    ST_SUSP_ENTER = 3'd1,
    ST_SUSP_GATED = 3'd2,
    ST_RESTORE    = 3'd3,
    ST_WAKE_WAIT  = 3'd4,
    ST_RESUME     = 3'd5
  } susp_st_e;
endpackage

// File: rtl/usb_susp_cnt.sv
module usb_susp_cnt #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  // saturating up-counter, clear wins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && (cnt_q != '1))   cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/usb_susp_fsm.sv
module usb_susp_fsm
  import usb_susp_pkg::*;
#(
  parameter int unsigned SETTLE_CYC    = 4,
  parameter int unsigned MIN_RESUME_MS = 20,
  parameter int unsigned WAKE_W        = 4,
  parameter int unsigned SET_W         = 3,
  parameter int unsigned MS_W          = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_req_i,
  input  logic              resume_req_i,
  input  logic              resume_clr_i,
  input  logic              rwake_det_i,
  input  logic [WAKE_W-1:0] wake_ms_i,
  input  logic [SET_W-1:0]  settle_cnt_i,
  input  logic [MS_W-1:0]   ms_cnt_i,
  output susp_st_e          st_o,
  output logic              cnt_clr_o
);
  localparam logic [SET_W-1:0] SettleLast = SET_W'(SETTLE_CYC - 1);
  localparam logic [MS_W-1:0]  ResumeMin  = MS_W'(MIN_RESUME_MS);

  susp_st_e          st_q, st_d;
  logic              remote_q, remote_d;
  logic              clr_pend_q, clr_pend_d;
  logic [WAKE_W-1:0] wake_len_q, wake_len_d;

  logic settle_done, wait_done, res_done, sw_exit;

  assign settle_done = (settle_cnt_i == SettleLast);
  assign wait_done   = (ms_cnt_i >= MS_W'(wake_len_q));
  assign res_done    = (ms_cnt_i >= ResumeMin);
  assign sw_exit     = res_done && (clr_pend_q || resume_clr_i);

  always_comb begin
    st_d       = st_q;
    remote_d   = remote_q;
    clr_pend_d = clr_pend_q;
    wake_len_d = wake_len_q;
    unique case (st_q)
      ST_NORMAL: begin
        if (suspend_req_i) st_d = ST_SUSP_ENTER;
      end
      ST_SUSP_ENTER: st_d = ST_SUSP_GATED;
      ST_SUSP_GATED: begin
        // software resume outranks remote wakeup
        if (resume_req_i) begin
          st_d     = ST_RESTORE;
          remote_d = 1'b0;
        end else if (rwake_det_i) begin
          st_d       = ST_RESTORE;
          remote_d   = 1'b1;
          wake_len_d = (wake_ms_i == '0) ? WAKE_W'(1) : wake_ms_i;
        end
      end
      ST_RESTORE: begin
        if (settle_done) st_d = remote_q ? ST_WAKE_WAIT : ST_RESUME;
      end
      ST_WAKE_WAIT: begin
        if (wait_done) st_d = ST_RESUME;
      end
      ST_RESUME: begin
        if (resume_clr_i) clr_pend_d = 1'b1;
        if (remote_q ? res_done : sw_exit) st_d = ST_NORMAL;
      end
      default: st_d = ST_NORMAL;
    endcase
    // a clear only counts once resume drive is under way
    if (st_d != st_q && (st_d == ST_RESUME || st_d == ST_NORMAL)) clr_pend_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_NORMAL;
      remote_q   <= 1'b0;
      clr_pend_q <= 1'b0;
      wake_len_q <= WAKE_W'(1);
    end else begin
      st_q       <= st_d;
      remote_q   <= remote_d;
      clr_pend_q <= clr_pend_d;
      wake_len_q <= wake_len_d;
    end
  end

  assign st_o      = st_q;
  assign cnt_clr_o = (st_d != st_q);
endmodule

// File: rtl/usb_host_susp_ctrl.sv
module usb_host_susp_ctrl
  import usb_susp_pkg::*;
#(
  parameter int unsigned SETTLE_CYC    = 4,
  parameter int unsigned MIN_RESUME_MS = 20,
  parameter int unsigned WAKE_W        = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              suspend_req_i,
  input  logic              resume_req_i,
  input  logic              resume_clr_i,
  input  logic              rwake_det_i,
  input  logic [WAKE_W-1:0] wake_ms_i,
  input  logic              ms_tick_i,
  output logic              port_susp_o,
  output logic              stop_phy_clk_o,
  output logic              bus_clk_gate_o,
  output logic              resume_drv_o,
  output logic              normal_op_o
);
  localparam int unsigned SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
  localparam int unsigned MS_W  = $clog2(MIN_RESUME_MS + (1 << WAKE_W) + 1);

  susp_st_e         st;
  logic             cnt_clr;
  logic [SET_W-1:0] settle_cnt;
  logic [MS_W-1:0]  ms_cnt;
  logic             settle_inc, ms_inc;

  assign settle_inc = (st == ST_RESTORE);
  assign ms_inc     = ms_tick_i && ((st == ST_WAKE_WAIT) || (st == ST_RESUME));

  usb_susp_fsm #(
    .SETTLE_CYC   (SETTLE_CYC),
    .MIN_RESUME_MS(MIN_RESUME_MS),
    .WAKE_W       (WAKE_W),
    .SET_W        (SET_W),
    .MS_W         (MS_W)
  ) u_fsm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .suspend_req_i(suspend_req_i),
    .resume_req_i (resume_req_i),
    .resume_clr_i (resume_clr_i),
    .rwake_det_i  (rwake_det_i),
    .wake_ms_i    (wake_ms_i),
    .settle_cnt_i (settle_cnt),
    .ms_cnt_i     (ms_cnt),
    .st_o         (st),
    .cnt_clr_o    (cnt_clr)
  );

  usb_susp_cnt #(.W(SET_W)) u_settle_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (settle_inc),
    .cnt_o (settle_cnt)
  );

  usb_susp_cnt #(.W(MS_W)) u_ms_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (cnt_clr),
    .inc_i (ms_inc),
    .cnt_o (ms_cnt)
  );

  always_comb begin
    port_susp_o    = 1'b0;
    stop_phy_clk_o = 1'b0;
    bus_clk_gate_o = 1'b0;
    resume_drv_o   = 1'b0;
    normal_op_o    = 1'b0;
    unique case (st)
      ST_NORMAL:     normal_op_o = 1'b1;
      ST_SUSP_ENTER: port_susp_o = 1'b1;
      ST_SUSP_GATED: begin
        port_susp_o    = 1'b1;
        stop_phy_clk_o = 1'b1;
        bus_clk_gate_o = 1'b1;
      end
      ST_RESTORE,
      ST_WAKE_WAIT:  port_susp_o  = 1'b1;
      ST_RESUME:     resume_drv_o = 1'b1;
      default:       normal_op_o  = 1'b1;
    endcase
  end
endmodule

// File: rtl/usb_host_susp_chk.sv
module usb_host_susp_chk #(
  parameter int unsigned MIN_RESUME_MS = 20
) (
  input logic clk_i,
  input logic rst_ni,
  input logic suspend_req_i,
  input logic ms_tick_i,
  input logic port_susp_o,
  input logic stop_phy_clk_o,
  input logic bus_clk_gate_o,
  input logic resume_drv_o,
  input logic normal_op_o
);
  logic [15:0] res_ticks_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                               res_ticks_q <= '0;
    else if (!resume_drv_o)                    res_ticks_q <= '0;
    else if (ms_tick_i && res_ticks_q != '1)   res_ticks_q <= res_ticks_q + 16'd1;
  end

  AST_GATE_IN_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_phy_clk_o || bus_clk_gate_o) |-> port_susp_o); // R2

  AST_GATE_AFTER_SUSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stop_phy_clk_o) |-> $past(port_susp_o)); // R2

  AST_RESUME_UNGATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_drv_o |-> (!stop_phy_clk_o && !bus_clk_gate_o)); // R4

  AST_RESUME_AFTER_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(resume_drv_o) |-> $past(port_susp_o && !stop_phy_clk_o && !bus_clk_gate_o)); // R3

  AST_RESUME_MIN_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(resume_drv_o) |-> (res_ticks_q >= 16'(MIN_RESUME_MS))); // R5

  AST_NORMAL_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    normal_op_o |-> !(port_susp_o || stop_phy_clk_o || bus_clk_gate_o || resume_drv_o)); // R7

  AST_SUSP_IGN_IN_RESUME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resume_drv_o && suspend_req_i) |=> !stop_phy_clk_o && !port_susp_o); // R9
endmodule

bind usb_host_susp_ctrl usb_host_susp_chk #(.MIN_RESUME_MS(MIN_RESUME_MS)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .suspend_req_i (suspend_req_i),
  .ms_tick_i     (ms_tick_i),
  .port_susp_o   (port_susp_o),
  .stop_phy_clk_o(stop_phy_clk_o),
  .bus_clk_gate_o(bus_clk_gate_o),
  .resume_drv_o  (resume_drv_o),
  .normal_op_o   (normal_op_o)
);

// File: tb/tb_usb_host_susp_ctrl.sv
module tb_usb_host_susp_ctrl;
  localparam int SETTLE = 4;
  localparam int MINMS  = 20;
  localparam int WW     = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic susp_req = 0, res_req = 0, res_clr = 0, rwake = 0, tick = 0;
  logic [WW-1:0] wake_ms = '0;
  logic port_susp, stop_phy, gate, res_drv, normal;

  int checks = 0, errors = 0;
  bit done = 0;
  int res_ticks = 0, wake_ticks = 0;
  bit prev_res = 0, prev_wph = 0;

  always #4 clk = ~clk;

  usb_host_susp_ctrl #(.SETTLE_CYC(SETTLE), .MIN_RESUME_MS(MINMS), .WAKE_W(WW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .suspend_req_i(susp_req), .resume_req_i(res_req),
    .resume_clr_i(res_clr), .rwake_det_i(rwake), .wake_ms_i(wake_ms), .ms_tick_i(tick),
    .port_susp_o(port_susp), .stop_phy_clk_o(stop_phy), .bus_clk_gate_o(gate),
    .resume_drv_o(res_drv), .normal_op_o(normal)
  );

  // ms tick: one cycle high every 10 cycles
  initial forever begin
    repeat (9) @(posedge clk);
    #1 tick = 1;
    @(posedge clk);
    #1 tick = 0;
  end

  // tick counters per phase, sampled mid-cycle
  always @(negedge clk) begin
    if (res_drv) begin
      if (!prev_res) res_ticks = 0;
      if (tick) res_ticks++;
    end
    prev_res = res_drv;
    if (port_susp && !stop_phy && !res_drv) begin
      if (!prev_wph) wake_ticks = 0;
      if (tick) wake_ticks++;
      prev_wph = 1;
    end else prev_wph = 0;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_res(input logic lvl, input int maxc, output int n);
    n = 0;
    while (res_drv !== lvl && n < maxc) begin
      @(negedge clk);
      n++;
    end
    #1;
  endtask

  task automatic chk_normal(input string req);
    chk(normal && !port_susp && !stop_phy && !gate && !res_drv, req,
        {normal, port_susp, stop_phy, gate, res_drv}, 5'b10000);
  endtask

  task automatic pulse_susp();
    @(posedge clk); #1 susp_req = 1;
    @(posedge clk); #1 susp_req = 0;
  endtask

  task automatic t_reset();
    #2;
    chk_normal("R1 in reset");
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk_normal("R1 after reset");
  endtask

  task automatic t_suspend();
    pulse_susp();
    @(negedge clk);
    chk(port_susp && !stop_phy && !gate, "R2 suspend first", {port_susp, stop_phy, gate}, 3'b100);
    @(negedge clk);
    chk(port_susp && stop_phy && gate, "R2 gated", {port_susp, stop_phy, gate}, 3'b111);
    repeat (25) @(negedge clk);
    chk(port_susp && stop_phy && gate && !res_drv, "R2 stays gated",
        {port_susp, stop_phy, gate, res_drv}, 4'b1110);
  endtask

  task automatic t_sw_resume(input bit early);
    int n, lows;
    @(posedge clk); #1 res_req = 1;
    @(posedge clk); #1 res_req = 0;
    @(negedge clk);
    chk(port_susp && !stop_phy && !gate && !res_drv, "R3 clocks first",
        {port_susp, stop_phy, gate, res_drv}, 4'b1000);
    lows = 1;
    repeat (20) begin
      @(negedge clk);
      if (res_drv) break;
      lows++;
    end
    chk(lows == SETTLE && res_drv && !port_susp, "R3 settle length", lows, SETTLE);
    chk(!stop_phy && !gate, "R4 ungated during resume", {stop_phy, gate}, 0);
    if (early) begin
      @(posedge clk); #1 res_clr = 1;
      @(posedge clk); #1 res_clr = 0;
      @(negedge clk);
      chk(res_drv == 1, "R5 early clear held off", res_drv, 1);
      wait_res(0, 2000, n);
      chk(res_ticks == MINMS, "R5 resume length", res_ticks, MINMS);
    end else begin
      repeat (300) @(negedge clk);
      chk(res_drv == 1, "R6 persists without clear", res_drv, 1);
      @(posedge clk); #1 res_clr = 1;
      @(posedge clk); #1 res_clr = 0;
      wait_res(0, 10, n);
      chk(n <= 3 && res_drv == 0, "R6 ends after clear", n, 3);
    end
    chk_normal("R7 back to normal");
  endtask

  task automatic t_remote(input logic [WW-1:0] w);
    int n, exp;
    exp = (w == 0) ? 1 : int'(w);
    wake_ms = w;
    @(posedge clk); #1 rwake = 1;
    @(posedge clk); #1 rwake = 0;
    @(negedge clk);
    chk(port_susp && !stop_phy && !gate, "R8 clocks restored", {port_susp, stop_phy, gate}, 3'b100);
    wait_res(1, 5000, n);
    chk(wake_ticks >= exp && wake_ticks <= exp + 1, "R8 wake wait", wake_ticks, exp);
    wait_res(0, 5000, n);
    chk(res_ticks == MINMS, "R8 self-ending resume", res_ticks, MINMS);
    chk_normal("R7 normal after remote");
  endtask

  task automatic t_ignore_normal();
    @(posedge clk); #1 res_req = 1; res_clr = 1; rwake = 1;
    @(posedge clk); #1 res_req = 0; res_clr = 0; rwake = 0;
    repeat (5) @(negedge clk);
    chk_normal("R10 stray requests ignored");
  endtask

  task automatic t_susp_during_resume();
    int n;
    pulse_susp();
    repeat (3) @(negedge clk);
    @(posedge clk); #1 res_req = 1;
    @(posedge clk); #1 res_req = 0; susp_req = 1;
    @(posedge clk); #1 susp_req = 0;
    wait_res(1, 100, n);
    @(posedge clk); #1 susp_req = 1; res_clr = 1;
    @(posedge clk); #1 susp_req = 0; res_clr = 0;
    wait_res(0, 2000, n);
    repeat (5) @(negedge clk);
    chk_normal("R9 suspend ignored during resume");
  endtask

  task automatic t_priority();
    int n;
    pulse_susp();
    repeat (3) @(negedge clk);
    wake_ms = 4'd15;
    @(posedge clk); #1 res_req = 1; rwake = 1;
    @(posedge clk); #1 res_req = 0; rwake = 0;
    wait_res(1, 5000, n);
    chk(n <= SETTLE + 2, "R11 no wake wait", n, SETTLE + 1);
    repeat (300) @(negedge clk);
    chk(res_drv == 1, "R11 needs clear", res_drv, 1);
    @(posedge clk); #1 res_clr = 1;
    @(posedge clk); #1 res_clr = 0;
    wait_res(0, 10, n);
    chk_normal("R11 ends on clear");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_ignore_normal();
    t_suspend();
    t_sw_resume(1'b1);
    t_suspend();
    t_sw_resume(1'b0);
    pulse_susp(); repeat (3) @(negedge clk);
    t_remote(4'd5);
    pulse_susp(); repeat (3) @(negedge clk);
    t_remote(4'd0);
    pulse_susp(); repeat (3) @(negedge clk);
    t_remote(4'd15);
    t_susp_during_resume();
    t_priority();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule